// File: doc/BRIEF.md
# Radix-4 Vector Inner Product Unit

The block forms the dot product of a vector of N signed input samples with a fixed vector of N signed coefficients. The coefficients are a parameter of the instance. Each input sample is split into radix-4 digits by modified Booth recoding. Each digit selects zero, one or two times its coefficient, possibly inverted, as a raw partial-product row. No product is ever resolved on its own. The rows of all N elements are gathered into one pool, along with one row of negation bits per element and a single constant row. That constant row cancels the sign-extension bias of every row. One shared tree of 4:2 compressors reduces the whole pool to a single sum/carry pair.

A pipeline register holds that redundant pair. One carry-propagate adder resolves it into the result, so the whole inner product uses a single final adder instead of one per element. A new vector may be offered on every clock cycle. Each accepted vector produces one result two cycles later, and the last result is held while no new one is due. The unit is meant to sit inside a transform engine, where one copy computes one output coefficient from a row or column of samples.

Top module: `vip_dot_top`

## Requirements
- R1: `out_valid` is high in exactly those cycles that follow, by two rising clock edges, an edge at which `in_valid` was sampled high.
- R2: Element i of `in_vec` is bits [i*XW +: XW] and coefficient i is bits [i*CW +: CW] of `COEF`, both two's complement. When `out_valid` is high, `result` equals the exact signed sum over i of element i times coefficient i, as an RW-bit two's complement value (RW = XW + CW + clog2(N)).
- R3: Vectors offered on consecutive cycles each yield their own correct result on consecutive cycles, in the order offered.
- R4: The result stays exact for extreme operands: every element at the most negative or the most positive value, alternating extremes, and every element at minus one.
- R5: After synchronous reset, `out_valid` is low and `result` is zero.
- R6: Input data offered while `in_valid` is low is ignored, and `result` keeps the last delivered value until the next result is due.
- R7: Each element position is weighted by its own coefficient only: a vector with a single nonzero element i yields that element times coefficient i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The vector on `in_vec` is to be processed |
| in_vec | input | N*XW | N packed signed samples, element 0 in the low bits |
| out_valid | output | 1 | `result` carries a new inner product this cycle |
| result | output | RW | Signed inner product, held between deliveries |

## Verification
A vector sampled at a rising edge has its result appear after the second rising edge that follows. The bench samples the outputs at falling edges, where that result is visible. For every applied vector, the bench pushes the behaviourally computed dot product into a two-deep expected pipeline. At each falling edge it compares `out_valid` and `result` with the entry pushed two steps earlier. When no result is due, the bench checks `result` against the last delivered value, which shows that data offered without `in_valid` never reaches the output.

// File: rtl/vip_pkg.sv
package vip_pkg;

    // Control lines of one radix-4 Booth digit
    typedef struct packed {
        logic neg;   // digit is negative
        logic two;   // magnitude two
        logic one;   // magnitude one
    } bsel_t;

    // Modified Booth recoding of the overlapping triple {b[2j+1], b[2j], b[2j-1]}
    function automatic bsel_t booth_sel(input logic [2:0] t);
        bsel_t s;
        s.neg = t[2] & ~(t[1] & t[0]);
        s.one = t[1] ^ t[0];
        s.two = (t == 3'b011) || (t == 3'b100);
        return s;
    endfunction

    // Rows left after one layer of 4:2 compressors; a group of three is
    // padded with a zero row so that it still shrinks
    function automatic int rows_next(input int r);
        int rem;
        rem = r % 4;
        return (r / 4) * 2 + ((rem == 3) ? 2 : rem);
    endfunction

    // Number of compressor layers needed to reach two rows
    function automatic int tree_levels(input int r0);
        int r;
        int l;
        r = r0;
        l = 0;
        while (r > 2) begin
            r = rows_next(r);
            l = l + 1;
        end
        return l;
    endfunction

    // Row count entering a given layer
    function automatic int rows_at(input int r0, input int lvl);
        int r;
        r = r0;
        for (int k = 0; k < lvl; k++) begin
            r = rows_next(r);
        end
        return r;
    endfunction

    // Sum of the biases removed from every partial-product row: each row
    // stores its value plus 2^(pw-1), shifted by two bits per digit
    function automatic logic [63:0] corr_const(input int n, input int d, input int pw);
        longint acc;
        acc = 0;
        for (int j = 0; j < d; j++) begin
            acc = acc - longint'(n) * (longint'(1) <<< (pw - 1 + 2 * j));
        end
        return acc;
    endfunction

endpackage

// File: rtl/vip_booth_rows.sv
module vip_booth_rows
    import vip_pkg::*;
#(
    parameter int XW = 8,
    parameter int CW = 8,
    parameter int RW = 19,
    parameter logic [CW-1:0] COEF = '0,
    localparam int D  = (XW + 1) / 2,
    localparam int PW = CW + 2
) (
    input  logic [XW-1:0] x,
    output logic [RW-1:0] pp [D],
    output logic [RW-1:0] neg_row
);

    // Coefficient multiples at partial-product width
    localparam logic [PW-1:0] M1 = PW'($signed(COEF));
    localparam logic [PW-1:0] M2 = M1 << 1;

    logic signed [2*D-1:0] xs;
    logic [2*D:0]          xe;
    logic [D-1:0]          negv;

    assign xs = (2*D)'($signed(x));
    assign xe = {xs, 1'b0};

    for (genvar j = 0; j < D; j++) begin : g_digit
        bsel_t         s;
        logic [PW-1:0] mag;
        logic [PW-1:0] inv;
        logic [PW-1:0] u;

        assign s    = booth_sel(xe[2*j+2 : 2*j]);
        assign mag  = s.two ? M2 : (s.one ? M1 : '0);
        assign inv  = mag ^ {PW{s.neg}};
        // flip the sign bit: the row becomes unsigned, bias removed by the constant row
        assign u    = {~inv[PW-1], inv[PW-2:0]};
        assign pp[j]   = RW'(u) << (2 * j);
        assign negv[j] = s.neg;
    end

    // the +1 of each two's complement negation lands at the digit weight
    always_comb begin
        neg_row = '0;
        for (int j = 0; j < D; j++) begin
            neg_row[2*j] = negv[j];
        end
    end

endmodule

// File: rtl/vip_cmp42.sv
module vip_cmp42 #(
    parameter int W = 19
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);

    // Two chained full adders per bit; the first adder's carry feeds the
    // second adder of the next bit. Top carries fall outside the word.
    logic [W-1:0] s1;
    logic [W-2:0] co;
    logic [W-2:0] c2;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            s1[i] = a[i] ^ b[i] ^ c[i];
        end
        for (int i = 0; i < W - 1; i++) begin
            co[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
        s[0] = s1[0] ^ d[0];
        for (int i = 1; i < W; i++) begin
            s[i] = s1[i] ^ d[i] ^ co[i-1];
        end
        c2[0] = s1[0] & d[0];
        for (int i = 1; i < W - 1; i++) begin
            c2[i] = (s1[i] & d[i]) | (s1[i] & co[i-1]) | (d[i] & co[i-1]);
        end
        cy = {c2, 1'b0};
    end

endmodule

// File: rtl/vip_cmp_tree.sv
module vip_cmp_tree
    import vip_pkg::*;
#(
    parameter int RW = 19,
    parameter int R0 = 41,
    localparam int LV = tree_levels(R0)
) (
    input  logic [RW-1:0] rows_in [R0],
    output logic [RW-1:0] sum_o,
    output logic [RW-1:0] carry_o
);

    for (genvar l = 0; l < LV; l++) begin : lv
        localparam int RI  = rows_at(R0, l);
        localparam int G   = RI / 4;
        localparam int REM = RI % 4;
        localparam int RO  = rows_next(RI);

        logic [RW-1:0] src [RI];
        logic [RW-1:0] nxt [RO];

        if (l == 0) begin : g_first
            assign src = rows_in;
        end else begin : g_more
            assign src = lv[l-1].nxt;
        end

        for (genvar g = 0; g < G; g++) begin : g_cmp
            vip_cmp42 #(.W(RW)) u_cmp (
                .a (src[4*g]),
                .b (src[4*g+1]),
                .c (src[4*g+2]),
                .d (src[4*g+3]),
                .s (nxt[2*g]),
                .cy(nxt[2*g+1])
            );
        end

        if (REM == 3) begin : g_pad
            vip_cmp42 #(.W(RW)) u_cmp (
                .a (src[4*G]),
                .b (src[4*G+1]),
                .c (src[4*G+2]),
                .d ('0),
                .s (nxt[2*G]),
                .cy(nxt[2*G+1])
            );
        end else begin : g_pass
            for (genvar k = 0; k < REM; k++) begin : g_row
                assign nxt[2*G+k] = src[4*G+k];
            end
        end
    end

    assign sum_o   = lv[LV-1].nxt[0];
    assign carry_o = lv[LV-1].nxt[1];

endmodule

// File: rtl/vip_dot_top.sv
module vip_dot_top
    import vip_pkg::*;
#(
    parameter int N  = 8,
    parameter int XW = 8,
    parameter int CW = 8,
    parameter logic [N*CW-1:0] COEF = 64'h1224_3240_4B53_5940,
    localparam int RW = XW + CW + $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [N*XW-1:0] in_vec,
    output logic            out_valid,
    output logic [RW-1:0]   result
);

    localparam int D  = (XW + 1) / 2;
    localparam int PW = CW + 2;
    localparam int RE = D + 1;          // rows per element: digits plus negation row
    localparam int R0 = N * RE + 1;     // plus the shared constant row
    localparam logic [63:0] CORR = corr_const(N, D, PW);

    typedef struct packed {
        logic            vld;
        logic [N*XW-1:0] vec;
    } in_stage_t;

    typedef struct packed {
        logic          vld;
        logic [RW-1:0] s;
        logic [RW-1:0] c;
    } red_stage_t;

    in_stage_t  st1;
    red_stage_t st2;

    logic [RW-1:0] rows [R0];
    logic [RW-1:0] tsum;
    logic [RW-1:0] tcar;

    // Partial-product rows of every element go into one pool
    for (genvar i = 0; i < N; i++) begin : g_elem
        logic [RW-1:0] pp [D];
        logic [RW-1:0] nrow;

        vip_booth_rows #(
            .XW  (XW),
            .CW  (CW),
            .RW  (RW),
            .COEF(COEF[i*CW +: CW])
        ) u_rows (
            .x      (st1.vec[i*XW +: XW]),
            .pp     (pp),
            .neg_row(nrow)
        );

        for (genvar j = 0; j < D; j++) begin : g_map
            assign rows[i*RE + j] = pp[j];
        end
        assign rows[i*RE + D] = nrow;
    end

    assign rows[R0-1] = CORR[RW-1:0];

    vip_cmp_tree #(
        .RW(RW),
        .R0(R0)
    ) u_tree (
        .rows_in(rows),
        .sum_o  (tsum),
        .carry_o(tcar)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
            st2 <= '0;
        end else begin
            st1.vld <= in_valid;
            if (in_valid) begin
                st1.vec <= in_vec;
            end
            st2.vld <= st1.vld;
            if (st1.vld) begin
                st2.s <= tsum;
                st2.c <= tcar;
            end
        end
    end

    // the single carry-propagate adder of the inner product
    assign result    = st2.s + st2.c;
    assign out_valid = st2.vld;

endmodule

// File: rtl/vip_dot_chk.sv
module vip_dot_chk #(
    parameter int N  = 8,
    parameter int XW = 8,
    parameter int CW = 8,
    parameter logic [N*CW-1:0] COEF = '0,
    localparam int RW = XW + CW + $clog2(N)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [N*XW-1:0] in_vec,
    input logic            out_valid,
    input logic [RW-1:0]   result
);

    function automatic logic [RW-1:0] behav(input logic [N*XW-1:0] v);
        longint acc;
        acc = 0;
        for (int i = 0; i < N; i++) begin
            acc = acc + longint'($signed(v[i*XW +: XW])) * longint'($signed(COEF[i*CW +: CW]));
        end
        return acc[RW-1:0];
    endfunction

    logic          m1v;
    logic          m2v;
    logic [RW-1:0] m1r;
    logic [RW-1:0] m2r;

    always_ff @(posedge clk) begin
        if (rst) begin
            m1v <= 1'b0;
            m2v <= 1'b0;
            m1r <= '0;
            m2r <= '0;
        end else begin
            m1v <= in_valid;
            m2v <= m1v;
            if (in_valid) begin
                m1r <= behav(in_vec);
            end
            if (m1v) begin
                m2r <= m1r;
            end
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == m2v);

    // R2
    dot_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> result == m2r);

    // R3
    stream_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !m1v |=> $stable(result));

    // R5
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && result == '0));

endmodule

bind vip_dot_top vip_dot_chk #(
    .N   (N),
    .XW  (XW),
    .CW  (CW),
    .COEF(COEF)
) i_vip_dot_chk (.*);

// File: tb/test_vip_dot_top.sv
module test_vip_dot_top;

    localparam int N  = 8;
    localparam int XW = 8;
    localparam int CW = 8;
    localparam int RW = XW + CW + 3;

    // bench copy of the coefficients, element 0 first
    localparam logic signed [CW-1:0] CB [N] = '{-8'sd128, 8'sd127, -8'sd1, 8'sd0,
                                                8'sd93, -8'sd77, 8'sd2, 8'sd64};
    localparam logic [N*CW-1:0] COEF = {8'h40, 8'h02, 8'hB3, 8'h5D,
                                        8'h00, 8'hFF, 8'h7F, 8'h80};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [N*XW-1:0] in_vec = '0;
    logic            out_valid;
    logic [RW-1:0]   result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic          p1v = 1'b0;
    logic          p2v = 1'b0;
    logic [RW-1:0] p1r = '0;
    logic [RW-1:0] p2r = '0;
    logic [RW-1:0] held = '0;
    string         p1t = "R2";
    string         p2t = "R2";

    always #4 clk = ~clk;

    vip_dot_top #(
        .N   (N),
        .XW  (XW),
        .CW  (CW),
        .COEF(COEF)
    ) i_vip_dot_top (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vec   (in_vec),
        .out_valid(out_valid),
        .result   (result)
    );

    function automatic logic [RW-1:0] ref_dot(input logic [N*XW-1:0] v);
        longint acc;
        acc = 0;
        for (int i = 0; i < N; i++) begin
            acc = acc + longint'($signed(v[i*XW +: XW])) * longint'(CB[i]);
        end
        return acc[RW-1:0];
    endfunction

    function automatic logic [N*XW-1:0] rand_vec();
        logic [N*XW-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[i*XW +: XW] = XW'($urandom());
        end
        return v;
    endfunction

    function automatic logic [N*XW-1:0] fill_vec(input logic [XW-1:0] a, input logic [XW-1:0] b);
        logic [N*XW-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[i*XW +: XW] = (i % 2 == 0) ? a : b;
        end
        return v;
    endfunction

    task automatic cmp(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    // One cycle: check what is due, then offer the next input
    task automatic step(input logic v, input logic [N*XW-1:0] x, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== p2v) begin
            errors++;
            $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, p2v);
        end
        if (p2v) begin
            held = p2r;
            cmp(p2t, result, p2r);
        end else begin
            cmp("R6", result, held);
        end
        p2v = p1v;
        p2r = p1r;
        p2t = p1t;
        p1v = v;
        p1r = ref_dot(x);
        p1t = tag;
        in_valid = v;
        in_vec = x;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R5: nothing delivered yet
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 out_valid actual %0b expected 0", out_valid);
        end
        cmp("R5", result, '0);

        // R7: one nonzero element per vector, idle gaps with noise (R6)
        for (int i = 0; i < N; i++) begin
            logic [N*XW-1:0] v;
            v = '0;
            v[i*XW +: XW] = (i % 2 == 0) ? 8'h80 : 8'h7F;
            step(1'b1, v, "R7");
            step(1'b0, rand_vec(), "R6");
            v = '0;
            v[i*XW +: XW] = 8'h35;
            step(1'b1, v, "R7");
        end

        // R4: extreme operand patterns
        step(1'b1, fill_vec(8'h7F, 8'h7F), "R4");
        step(1'b1, fill_vec(8'h80, 8'h80), "R4");
        step(1'b0, rand_vec(), "R6");
        step(1'b1, fill_vec(8'h80, 8'h7F), "R4");
        step(1'b1, fill_vec(8'h7F, 8'h80), "R4");
        step(1'b1, fill_vec(8'hFF, 8'hFF), "R4");
        step(1'b1, fill_vec(8'h00, 8'h00), "R4");

        // R2: random vectors, valid on about three cycles of four
        for (int k = 0; k < 150; k++) begin
            logic vv;
            vv = ($urandom() % 4) != 0;
            step(vv, rand_vec(), "R2");
        end

        // R3: uninterrupted stream
        for (int k = 0; k < 40; k++) begin
            step(1'b1, rand_vec(), "R3");
        end

        repeat (3) step(1'b0, rand_vec(), "R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule